// File: doc/BRIEF.md
# Half-bridge synchronous-rectifier drive sequencer

This block turns one pulse-width request into four interlocked logic-level drives for a half-bridge converter. Two outputs go to the low-side and high-side primary switches. The other two go to the secondary synchronous rectifiers. Each accepted switching cycle belongs to one side of the bridge, and the side alternates from one accepted cycle to the next. The low side always comes first after the block is enabled, so that the high-side bootstrap supply can charge.

Within a cycle the sequence has four steps. The secondary drive of the active side is raised first, which turns that rectifier off. The primary switch is enabled only after a programmable lead gap. The primary stays on while the request stays high. When the request ends, the primary is switched off, and the secondary is released back to the idle state after a programmable trail gap. Each side has its own lead gap and its own trail gap, and all four are counted in clock cycles.

The pins are plain control levels. There is no data stream, so there is no valid/ready handshake and no back-pressure. Cycle strobes that arrive while a cycle is still in progress are dropped.

Top module: `hbs_drive_seq`

## Requirements
- R1: `phase` is the side of the next cycle (0 = low, 1 = high). It flips on every cycle strobe that is accepted, whether or not a pulse follows. A strobe is accepted only while the sequencer is idle and `run_en` is high.
- R2: After `run_en` rises, the first accepted cycle uses the low side, so `pri_lo` switches before `pri_hi` does.
- R3: A cycle starts with a strobe at clock edge n0 while `pwm_on` is high. The active side's secondary output rises at edge n0. Its primary output rises at edge n0+G, where G is that side's lead gap (`gap_lo_on` or `gap_hi_on`).
- R4: The secondary output falls at edge m+T, where m is the edge at which the primary fell and T is that side's trail gap (`gap_lo_off` or `gap_hi_off`).
- R5: A gap value of 0 behaves as 1 clock cycle.
- R6: Secondary encoding: `sec_lo`=`sec_hi`=0 is the idle state, with both rectifiers conducting. `sec_lo`=1 goes with a low-side cycle and `sec_hi`=1 goes with a high-side cycle. While `pri_lo` is high, `sec_lo`=1 and `sec_hi`=0. While `pri_hi` is high, `sec_hi`=1 and `sec_lo`=0.
- R7: `pri_lo` and `pri_hi` are never high together.
- R8: In a high-side cycle, `hs_hold` has two effects. If it is high at the strobe, the cycle produces no output change. If it is sampled high during the pulse, `pri_hi` falls at that edge. It has no effect on low-side cycles.
- R9: While `run_en` is low, all four outputs are low without waiting for a clock edge, and the sequencer returns to idle.
- R10: If `pwm_on` is sampled low at an edge before the lead gap has expired, no primary pulse is produced, and the secondary output falls at that same edge.
- R11: A strobe that arrives while a cycle is in progress causes no output change and does not flip the phase.
- R12: Once the primary is on, it falls at the first edge at which `pwm_on` is sampled low.
- R13: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run_en | input | 1 | Enable; low forces all drives off |
| cyc_strobe | input | 1 | One-cycle switching-cycle start |
| pwm_on | input | 1 | Pulse request level |
| hs_hold | input | 1 | Inhibits high-side switching |
| gap_lo_on | input | W | Lead gap, low-side secondary to primary, in cycles |
| gap_lo_off | input | W | Trail gap, low-side primary to secondary, in cycles |
| gap_hi_on | input | W | Lead gap, high side, in cycles |
| gap_hi_off | input | W | Trail gap, high side, in cycles |
| pri_lo | output | 1 | Low-side primary enable |
| pri_hi | output | 1 | High-side primary enable |
| sec_lo | output | 1 | Low-side cycle secondary drive |
| sec_hi | output | 1 | High-side cycle secondary drive |

## Verification
The gap properties assume that the four gap inputs hold steady from the strobe until the sequencer is idle again. A value that changed mid-cycle would make the measured interval meaningless. The properties are also turned off while `run_en` is low, because a forced shutdown ends pulses and rectifier states outside the normal sequence. The stimulus changes gaps only between cycles. It drives every input on the falling clock edge, and it waits out each trail gap before the next strobe, except in the test that deliberately sends a strobe during a busy cycle.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_ON    = 2'd2,
    ST_TRAIL = 2'd3
  } seq_st_t;

  typedef enum logic {
    SIDE_LO = 1'b0,
    SIDE_HI = 1'b1
  } side_t;

  localparam int GAP_SEL_N = 4;
endpackage

// File: rtl/hbs_phase.sv
module hbs_phase
  import hbs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  adv,
  output side_t phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase <= SIDE_LO;
    else if (clr) phase <= SIDE_LO;
    else if (adv) phase <= (phase == SIDE_LO) ? SIDE_HI : SIDE_LO;
  end
endmodule

// File: rtl/hbs_gap_sel.sv
module hbs_gap_sel
  import hbs_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] gap_lo_on,
  input  logic [W-1:0] gap_lo_off,
  input  logic [W-1:0] gap_hi_on,
  input  logic [W-1:0] gap_hi_off,
  input  side_t        side,
  input  logic         trail,
  output logic [W-1:0] gap_val
);
  localparam int SW = $clog2(GAP_SEL_N);

  logic [W-1:0] raw  [GAP_SEL_N];
  logic [W-1:0] norm [GAP_SEL_N];
  logic [SW-1:0] idx;

  assign raw[0] = gap_lo_on;
  assign raw[1] = gap_lo_off;
  assign raw[2] = gap_hi_on;
  assign raw[3] = gap_hi_off;

  for (genvar g = 0; g < GAP_SEL_N; g++) begin : g_norm
    assign norm[g] = (raw[g] == '0) ? W'(1) : raw[g];
  end

  assign idx     = {side, trail};
  assign gap_val = norm[idx];
endmodule

// File: rtl/hbs_gap_timer.sv
module hbs_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (tick && cnt != '0) cnt <= cnt - W'(1);
  end

  assign last = (cnt == W'(1));
endmodule

// File: rtl/hbs_seq_fsm.sv
module hbs_seq_fsm
  import hbs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  logic    strobe,
  input  logic    req,
  input  logic    hold,
  input  side_t   phase,
  input  logic    tmr_last,
  output logic    accept,
  output logic    tmr_load,
  output logic    tmr_tick,
  output logic    sel_trail,
  output side_t   sel_side,
  output seq_st_t st,
  output side_t   act_side
);
  seq_st_t nxt;
  logic    go;
  logic    start_ok;

  assign go       = req && !(act_side == SIDE_HI && hold);
  assign start_ok = req && !(phase == SIDE_HI && hold);

  always_comb begin
    nxt      = st;
    accept   = 1'b0;
    tmr_load = 1'b0;
    tmr_tick = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (strobe) begin
          accept = 1'b1;
          if (start_ok) begin
            nxt      = ST_LEAD;
            tmr_load = 1'b1;
          end
        end
      end
      ST_LEAD: begin
        if (!go)           nxt = ST_IDLE;
        else if (tmr_last) nxt = ST_ON;
        else               tmr_tick = 1'b1;
      end
      ST_ON: begin
        if (!go) begin
          nxt      = ST_TRAIL;
          tmr_load = 1'b1;
        end
      end
      ST_TRAIL: begin
        if (tmr_last) nxt = ST_IDLE;
        else          tmr_tick = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
    if (!run) begin
      nxt      = ST_IDLE;
      accept   = 1'b0;
      tmr_load = 1'b0;
      tmr_tick = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      act_side <= SIDE_LO;
    end else begin
      st <= nxt;
      if (accept) act_side <= phase;
    end
  end

  assign sel_side  = (st == ST_IDLE) ? phase : act_side;
  assign sel_trail = (st == ST_ON);
endmodule

// File: rtl/hbs_drive_seq.sv
module hbs_drive_seq
  import hbs_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         cyc_strobe,
  input  logic         pwm_on,
  input  logic         hs_hold,
  input  logic [W-1:0] gap_lo_on,
  input  logic [W-1:0] gap_lo_off,
  input  logic [W-1:0] gap_hi_on,
  input  logic [W-1:0] gap_hi_off,
  output logic         pri_lo,
  output logic         pri_hi,
  output logic         sec_lo,
  output logic         sec_hi
);
  side_t        phase;
  side_t        sel_side;
  side_t        act_side;
  seq_st_t      st;
  logic         accept;
  logic         tmr_load;
  logic         tmr_tick;
  logic         tmr_last;
  logic         sel_trail;
  logic [W-1:0] gap_val;

  hbs_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!run_en),
    .adv   (accept),
    .phase (phase)
  );

  hbs_gap_sel #(.W(W)) u_sel (
    .gap_lo_on  (gap_lo_on),
    .gap_lo_off (gap_lo_off),
    .gap_hi_on  (gap_hi_on),
    .gap_hi_off (gap_hi_off),
    .side       (sel_side),
    .trail      (sel_trail),
    .gap_val    (gap_val)
  );

  hbs_gap_timer #(.W(W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!run_en),
    .load     (tmr_load),
    .load_val (gap_val),
    .tick     (tmr_tick),
    .last     (tmr_last)
  );

  hbs_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_en),
    .strobe    (cyc_strobe),
    .req       (pwm_on),
    .hold      (hs_hold),
    .phase     (phase),
    .tmr_last  (tmr_last),
    .accept    (accept),
    .tmr_load  (tmr_load),
    .tmr_tick  (tmr_tick),
    .sel_trail (sel_trail),
    .sel_side  (sel_side),
    .st        (st),
    .act_side  (act_side)
  );

  // Drives are gated by run_en so a shutdown takes effect without a clock edge.
  assign pri_lo = run_en && (st == ST_ON)   && (act_side == SIDE_LO);
  assign pri_hi = run_en && (st == ST_ON)   && (act_side == SIDE_HI);
  assign sec_lo = run_en && (st != ST_IDLE) && (act_side == SIDE_LO);
  assign sec_hi = run_en && (st != ST_IDLE) && (act_side == SIDE_HI);
endmodule

// File: rtl/hbs_drive_seq_chk.sv
module hbs_drive_seq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_en,
  input logic         hs_hold,
  input logic [W-1:0] gap_lo_on,
  input logic [W-1:0] gap_lo_off,
  input logic [W-1:0] gap_hi_on,
  input logic [W-1:0] gap_hi_off,
  input logic         pri_lo,
  input logic         pri_hi,
  input logic         sec_lo,
  input logic         sec_hi
);
  localparam int AW = W + 2;
  localparam logic [AW-1:0] AMAX = '1;

  function automatic logic [AW-1:0] nz(input logic [W-1:0] v);
    return (v == '0) ? AW'(1) : AW'(v);
  endfunction

  logic [AW-1:0] age_lo, age_hi, off_lo, off_hi;
  logic          pulsed_lo, pulsed_hi, seen_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_lo <= '0; age_hi <= '0; off_lo <= '0; off_hi <= '0;
      pulsed_lo <= 1'b0; pulsed_hi <= 1'b0; seen_lo <= 1'b0;
    end else begin
      age_lo <= !sec_lo ? '0 : (age_lo == AMAX ? age_lo : age_lo + AW'(1));
      age_hi <= !sec_hi ? '0 : (age_hi == AMAX ? age_hi : age_hi + AW'(1));
      off_lo <= pri_lo ? '0 : (off_lo == AMAX ? off_lo : off_lo + AW'(1));
      off_hi <= pri_hi ? '0 : (off_hi == AMAX ? off_hi : off_hi + AW'(1));
      pulsed_lo <= !sec_lo ? 1'b0 : (pulsed_lo || pri_lo);
      pulsed_hi <= !sec_hi ? 1'b0 : (pulsed_hi || pri_hi);
      seen_lo   <= !run_en ? 1'b0 : (seen_lo || pri_lo);
    end
  end

  assert_pri_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pri_lo, pri_hi}));

  assert_lo_sec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pri_lo |-> (sec_lo && !sec_hi));

  assert_hi_sec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pri_hi |-> (sec_hi && !sec_lo));

  assert_lo_lead_R3: assert property (@(posedge clk) disable iff (!rst_n || !run_en)
    $rose(pri_lo) |-> (age_lo >= nz(gap_lo_on)));

  assert_hi_lead_R3: assert property (@(posedge clk) disable iff (!rst_n || !run_en)
    $rose(pri_hi) |-> (age_hi >= nz(gap_hi_on)));

  assert_lo_trail_R4: assert property (@(posedge clk) disable iff (!rst_n || !run_en)
    ($fell(sec_lo) && pulsed_lo) |-> (off_lo >= nz(gap_lo_off)));

  assert_hi_trail_R4: assert property (@(posedge clk) disable iff (!rst_n || !run_en)
    ($fell(sec_hi) && pulsed_hi) |-> (off_hi >= nz(gap_hi_off)));

  assert_first_lo_R2: assert property (@(posedge clk) disable iff (!rst_n || !run_en)
    $rose(pri_hi) |-> seen_lo);

  assert_hold_stop_R8: assert property (@(posedge clk) disable iff (!rst_n || !run_en)
    (pri_hi && hs_hold) |=> !pri_hi);

  assert_run_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !(pri_lo || pri_hi || sec_lo || sec_hi));
endmodule

bind hbs_drive_seq hbs_drive_seq_chk #(.W(W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .hs_hold    (hs_hold),
  .gap_lo_on  (gap_lo_on),
  .gap_lo_off (gap_lo_off),
  .gap_hi_on  (gap_hi_on),
  .gap_hi_off (gap_hi_off),
  .pri_lo     (pri_lo),
  .pri_hi     (pri_hi),
  .sec_lo     (sec_lo),
  .sec_hi     (sec_hi)
);

// File: tb/test_hbs_drive_seq.sv
module test_hbs_drive_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic       cyc_strobe = 1'b0;
  logic       pwm_on = 1'b0;
  logic       hs_hold = 1'b0;
  logic [7:0] gap_lo_on = 8'd3, gap_lo_off = 8'd2, gap_hi_on = 8'd4, gap_hi_off = 8'd5;
  logic       pri_lo, pri_hi, sec_lo, sec_hi;

  int  cyc = 0;
  int  vectors = 0;
  int  fails = 0;
  bit  done = 1'b0;
  bit  phase_m = 1'b0;
  bit  first_m = 1'b1;

  typedef struct {
    int    c;
    int    s;
    bit    v;
    string r;
  } ev_t;
  ev_t exp_q[$];

  hbs_drive_seq #(.W(8)) i_hbs_drive_seq (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cyc_strobe(cyc_strobe),
    .pwm_on(pwm_on), .hs_hold(hs_hold),
    .gap_lo_on(gap_lo_on), .gap_lo_off(gap_lo_off),
    .gap_hi_on(gap_hi_on), .gap_hi_off(gap_hi_off),
    .pri_lo(pri_lo), .pri_hi(pri_hi), .sec_lo(sec_lo), .sec_hi(sec_hi)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ef(input logic [7:0] v);
    return (v == 8'd0) ? 1 : int'(v);
  endfunction

  task automatic push(input int c, input int s, input bit v, input string r);
    ev_t e;
    e.c = c; e.s = s; e.v = v; e.r = r;
    exp_q.push_back(e);
  endtask

  task automatic check(input bit ok, input string r, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, expv);
    end
  endtask

  // Monitor: detects output edges and compares them with the scoreboard queue.
  logic [3:0] prev = 4'b0;
  always @(posedge clk) begin
    logic [3:0] cur;
    #1;
    cur = {sec_hi, sec_lo, pri_hi, pri_lo};
    check(!(cur[0] && cur[1]), "R7 primaries exclusive", int'(cur), 0);
    check(!(cur[0] && !(cur[2] && !cur[3])) && !(cur[1] && !(cur[3] && !cur[2])),
          "R6 secondary state during primary", int'(cur), 0);
    for (int s = 0; s < 4; s++) begin
      if (cur[s] != prev[s]) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected edge", cyc * 10 + s, -1);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          check(e.c == cyc && e.s == s && e.v == cur[s], e.r,
                cyc * 100 + s * 10 + int'(cur[s]), e.c * 100 + e.s * 10 + int'(e.v));
        end
      end
    end
    prev = cur;
  end

  // Driver: one switching cycle. L = request length in edges, hk = edge offset at
  // which hs_hold rises (-1 none), bj = edge offset of a strobe while busy (-1 none).
  task automatic run_cycle(input int L, input int hk, input int bj);
    int d, t, n0, le;
    bit s;
    @(negedge clk);
    n0 = cyc + 1;
    s = phase_m;
    phase_m = ~phase_m;
    d = s ? ef(gap_hi_on) : ef(gap_lo_on);
    t = s ? ef(gap_hi_off) : ef(gap_lo_off);
    le = L;
    if (s && hk >= 0 && hk < le) le = hk;
    cyc_strobe = 1'b1;
    pwm_on = (L > 0);
    hs_hold = (hk == 0);
    if (le >= d + 1) begin
      push(n0, 2 + int'(s), 1'b1, first_m ? "R2 low side first" : "R1 alternation");
      push(n0 + d, int'(s), 1'b1, "R3 lead gap");
      push(n0 + le, int'(s), 1'b0, (le < L) ? "R8 hold ends high pulse" : "R12 pulse end");
      push(n0 + le + t, 2 + int'(s), 1'b0, "R4 trail gap");
    end else if (le >= 1) begin
      push(n0, 2 + int'(s), 1'b1, "R6 secondary off first");
      push(n0 + le, 2 + int'(s), 1'b0, "R10 short request");
    end
    first_m = 1'b0;
    for (int j = 1; j <= L; j++) begin
      @(negedge clk);
      cyc_strobe = (j == bj);
      if (j == hk) hs_hold = 1'b1;
      if (j == L) pwm_on = 1'b0;
    end
    @(negedge clk);
    cyc_strobe = 1'b0;
    hs_hold = 1'b0;
    pwm_on = 1'b0;
    repeat (t + 3) @(negedge clk);
  endtask

  // Drop run_en m edges into a low-side pulse.
  task automatic run_drop(input int L, input int m);
    int n0, d;
    @(negedge clk);
    n0 = cyc + 1;
    d = ef(gap_lo_on);
    phase_m = ~phase_m;
    cyc_strobe = 1'b1;
    pwm_on = 1'b1;
    push(n0, 2, 1'b1, "R1 alternation");
    push(n0 + d, 0, 1'b1, "R3 lead gap");
    for (int j = 1; j < m; j++) begin
      @(negedge clk);
      cyc_strobe = 1'b0;
    end
    @(negedge clk);
    run_en = 1'b0;
    push(n0 + m, 0, 1'b0, "R9 shutdown primary");
    push(n0 + m, 2, 1'b0, "R9 shutdown secondary");
    #1;
    check({pri_lo, pri_hi, sec_lo, sec_hi} == 4'b0, "R9 immediate off",
          int'({pri_lo, pri_hi, sec_lo, sec_hi}), 0);
    if (L > m) pwm_on = 1'b0;
    repeat (4) @(negedge clk);
    run_en = 1'b1;
    phase_m = 1'b0;
    first_m = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({pri_lo, pri_hi, sec_lo, sec_hi} == 4'b0, "R13 reset state",
          int'({pri_lo, pri_hi, sec_lo, sec_hi}), 0);
    run_en = 1'b1;
    phase_m = 1'b0;
    first_m = 1'b1;
    repeat (2) @(negedge clk);
    check({pri_lo, pri_hi, sec_lo, sec_hi} == 4'b0, "R6 idle both rectifiers on",
          int'({pri_lo, pri_hi, sec_lo, sec_hi}), 0);

    // R1 R3 R4 R12: alternating pulses with distinct gaps per edge
    run_cycle(10, -1, -1);
    run_cycle(12, -1, -1);
    run_cycle(8, -1, -1);
    run_cycle(9, -1, -1);

    // R5: zero gaps act as one cycle
    gap_lo_on = 0; gap_lo_off = 0; gap_hi_on = 0; gap_hi_off = 0;
    run_cycle(5, -1, -1);
    run_cycle(2, -1, -1);

    // R10: requests ending inside the lead gap
    gap_lo_on = 6; gap_lo_off = 3; gap_hi_on = 6; gap_hi_off = 4;
    run_cycle(3, -1, -1);
    run_cycle(6, -1, -1);
    run_cycle(7, -1, -1);
    run_cycle(7, -1, -1);

    // R8: hold from strobe on the high side, hold ignored on the low side
    run_cycle(10, 0, -1);
    run_cycle(10, 0, -1);
    // R8: hold rising mid high-side pulse
    run_cycle(10, 2, -1);
    run_cycle(14, 9, -1);

    // R11: strobe while busy is ignored; the next cycle shows phase untouched
    run_cycle(12, -1, 8);
    run_cycle(9, -1, -1);

    // R9 then R2: shutdown mid pulse, restart low side first
    run_drop(20, 9);
    run_cycle(10, -1, -1);
    run_cycle(10, -1, -1);

    // Long gaps
    gap_lo_on = 255; gap_lo_off = 200; gap_hi_on = 130; gap_hi_off = 255;
    run_cycle(300, -1, -1);
    run_cycle(140, -1, -1);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "all expected edges seen", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule